// File: doc/BRIEF.md
# Two-Level Group and Ring Service Scheduler

This block decides which descriptor ring a consumer should service next. Rings are arranged into groups of equal size. On each request the scheduler first chooses a group. It takes the groups in round-robin order, moves on by one group for every grant, and skips any group that has no pending work. It then chooses one ring inside that group.

Inside a group, rings flagged as strict priority are served before all others. Among those, the lowest index wins. Only when no strict ring has work does the scheduler fall back to the weighted set. There a deficit-style pointer gives each ring up to its configured weight in consecutive grants before moving on. Each group keeps its own weighted pointer and credit count.

The consumer pulses a request, and one cycle later the scheduler presents a registered group index, a ring index and a valid flag. The block does not move descriptors and does not classify traffic.

Top module: `gsched_top`

## Requirements
- R1: After reset `grant_valid` is low, and the group pointer, every group's weighted pointer and every credit count are zero. The first grants after reset therefore start their searches at group 0 and at weighted ring 0.
- R2: `grant_valid` is high in the cycle after a cycle with `req` high in which at least one ring was non-empty, and low otherwise. `grant_group` and `grant_ring` change only on a grant and hold their values between grants.
- R3: The group search starts at the group pointer and wraps around. It skips groups with no non-empty ring. After a grant the pointer becomes the granted group plus one, modulo the group count.
- R4: Within the chosen group, any non-empty strict-priority ring is chosen ahead of every weighted ring.
- R5: Among several non-empty strict-priority rings in a group, the lowest ring index is chosen.
- R6: A weighted ring whose weight is w receives up to w consecutive grants in its group. The group's weighted pointer then moves to the next ring.
- R7: Empty weighted rings are skipped without consuming credit. When the ring at the pointer is empty or out of credit, the search continues from the next ring index, wrapping around, and the ring it finds starts with a fresh credit count.
- R8: A configured weight of zero behaves as a weight of one.
- R9: A strict-priority grant leaves the group's weighted pointer and credit count unchanged.
- R10: Ring r of group g uses flat index g*RINGS+r. That index gives its bit in `ring_nonempty` and in `ring_strict`, and `ring_weight` bits [(g*RINGS+r)*WW +: WW] hold its weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Consumer asks for a new selection |
| ring_nonempty | input | GROUPS*RINGS | Per-ring work-pending flags |
| ring_strict | input | GROUPS*RINGS | Per-ring strict-priority configuration |
| ring_weight | input | GROUPS*RINGS*WW | Per-ring weight configuration |
| grant_valid | output | 1 | Registered selection is valid |
| grant_group | output | $clog2(GROUPS) | Selected group index |
| grant_ring | output | $clog2(RINGS) | Selected ring index within the group |

## Verification
A corrupted group pointer shows at the very next grant as a group out of rotation order, or as a visit to an empty group. A corrupted weighted pointer or credit count shows within one weight period as a grant burst that is too long or too short, or as a ring served out of turn. The stimulus therefore checks runs of consecutive grants against hand-computed sequences instead of single grants. It also confirms that strict grants in between leave the weighted rotation where it was.

// File: rtl/gsched_pkg.sv
package gsched_pkg;
  // Advance an index by one with wrap at limit n.
  function automatic int wrap_next(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/gsched_rr_pick.sv
module gsched_rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = start;
    for (int i = 0; i < N; i++) begin
      int j;
      j = int'(start) + i;
      if (j >= N) j = j - N;
      if (!found && vec[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end

  always_comb begin
    if (found) begin
      p_pick_is_set_r3: assert (vec[idx]) else $error("picked index not set");
    end
  end
endmodule

// File: rtl/gsched_ring_sel.sv
module gsched_ring_sel
  import gsched_pkg::*;
#(
  parameter int R  = 4,
  parameter int WW = 4,
  localparam int RW = (R > 1) ? $clog2(R) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [R-1:0]  ne,
  input  logic [R-1:0]  strict,
  input  logic [R*WW-1:0] weight,
  input  logic          take,
  output logic          has_work,
  output logic [RW-1:0] pick,
  output logic          pick_strict
);
  logic [RW-1:0] wptr_q, wptr_d;
  logic [WW:0]   used_q, used_d;
  logic [R-1:0]  s_vec, w_vec;
  logic          s_found, w_found;
  logic [RW-1:0] s_idx, w_srch_idx, w_idx, srch_start;
  logic          stay;
  logic [WW:0]   weff_ptr, weff_sel, used_new;

  function automatic logic [WW:0] eff_weight(input logic [WW-1:0] w);
    return (w == '0) ? (WW+1)'(1) : {1'b0, w};
  endfunction

  assign s_vec = ne & strict;
  assign w_vec = ne & ~strict;
  assign srch_start = RW'(wrap_next(int'(wptr_q), R));

  gsched_rr_pick #(.N(R)) u_strict (
    .vec(s_vec), .start('0), .found(s_found), .idx(s_idx));
  gsched_rr_pick #(.N(R)) u_wsrch (
    .vec(w_vec), .start(srch_start), .found(w_found), .idx(w_srch_idx));

  always_comb begin
    weff_ptr    = eff_weight(weight[int'(wptr_q)*WW +: WW]);
    stay        = w_vec[wptr_q] && (used_q < weff_ptr);
    w_idx       = stay ? wptr_q : w_srch_idx;
    weff_sel    = eff_weight(weight[int'(w_idx)*WW +: WW]);
    has_work    = s_found || w_found || stay;
    pick_strict = s_found;
    pick        = s_found ? s_idx : w_idx;
    used_new    = (stay ? used_q : '0) + (WW+1)'(1);
    wptr_d      = wptr_q;
    used_d      = used_q;
    if (take && !s_found && (stay || w_found)) begin
      if (used_new >= weff_sel) begin
        wptr_d = RW'(wrap_next(int'(w_idx), R));
        used_d = '0;
      end else begin
        wptr_d = w_idx;
        used_d = used_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      used_q <= '0;
    end else if (take) begin
      wptr_q <= wptr_d;
      used_q <= used_d;
    end
  end

  p_strict_keeps_credit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pick_strict) |=> ($stable(wptr_q) && $stable(used_q)))
    else $error("strict grant disturbed weighted state");
endmodule

// File: rtl/gsched_top.sv
module gsched_top
  import gsched_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int RINGS  = 4,
  parameter int WW     = 4,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int RW = (RINGS > 1) ? $clog2(RINGS) : 1,
  localparam int NR = GROUPS * RINGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [NR-1:0]    ring_nonempty,
  input  logic [NR-1:0]    ring_strict,
  input  logic [NR*WW-1:0] ring_weight,
  output logic             grant_valid,
  output logic [GW-1:0]    grant_group,
  output logic [RW-1:0]    grant_ring
);
  logic [GROUPS-1:0] gwork, take;
  logic [RW-1:0]     gpick [GROUPS];
  logic [GROUPS-1:0] gstrict;
  logic [GW-1:0]     gptr_q, gptr_d, gsel;
  logic              gfound, fire;
  logic              valid_d;
  logic [GW-1:0]     group_d;
  logic [RW-1:0]     ring_d;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign take[g] = fire && (gsel == GW'(g));
    gsched_ring_sel #(.R(RINGS), .WW(WW)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .ne(ring_nonempty[g*RINGS +: RINGS]),
      .strict(ring_strict[g*RINGS +: RINGS]),
      .weight(ring_weight[g*RINGS*WW +: RINGS*WW]),
      .take(take[g]),
      .has_work(gwork[g]),
      .pick(gpick[g]),
      .pick_strict(gstrict[g]));
  end

  gsched_rr_pick #(.N(GROUPS)) u_grp (
    .vec(gwork), .start(gptr_q), .found(gfound), .idx(gsel));

  always_comb begin
    fire    = req && gfound;
    valid_d = fire;
    gptr_d  = fire ? GW'(wrap_next(int'(gsel), GROUPS)) : gptr_q;
    group_d = fire ? gsel : grant_group;
    ring_d  = fire ? gpick[gsel] : grant_ring;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gptr_q      <= '0;
      grant_valid <= 1'b0;
      grant_group <= '0;
      grant_ring  <= '0;
    end else begin
      grant_valid <= valid_d;
      if (fire) begin
        gptr_q      <= gptr_d;
        grant_group <= group_d;
        grant_ring  <= ring_d;
      end
    end
  end

  p_valid_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(req)) else $error("valid without request");

  p_empty_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (ring_nonempty == '0)) |=> !grant_valid)
    else $error("grant with all rings empty");

  p_work_gets_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (ring_nonempty != '0)) |=> grant_valid)
    else $error("pending work not granted");

  p_hold_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req) |-> ($stable(grant_group) && $stable(grant_ring)))
    else $error("indices moved without request");

  p_strict_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ((ring_nonempty[gsel*RINGS +: RINGS] & ring_strict[gsel*RINGS +: RINGS]) != '0))
    |-> gstrict[gsel]) else $error("weighted ring beat strict ring");
endmodule

// File: tb/sim_gsched_top.sv
module sim_gsched_top;
  localparam int G = 4, R = 4, WW = 4, NR = 16, NV = 5;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [NR-1:0] ne = '0, st = '0;
  logic [NR*WW-1:0] wt = {16{4'h1}};
  logic grant_valid;
  logic [1:0] grant_group, grant_ring;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gsched_top #(.GROUPS(G), .RINGS(R), .WW(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req),
    .ring_nonempty(ne), .ring_strict(st), .ring_weight(wt),
    .grant_valid(grant_valid), .grant_group(grant_group), .grant_ring(grant_ring));

  // Vector table: nonempty, strict, weights, four expected grants {group,ring}
  localparam logic [15:0] V_NE [NV] = '{16'h0006, 16'h0003, 16'h000D, 16'h1011, 16'h0030};
  localparam logic [15:0] V_ST [NV] = '{16'h0000, 16'h0000, 16'h000C, 16'h0000, 16'h0000};
  localparam logic [63:0] V_WT [NV] = '{64'h1111_1111_1111_1111, 64'h1111_1111_1111_1113,
                                         64'h1111_1111_1111_1111, 64'h1111_1111_1111_1111,
                                         64'h1111_1111_1100_1111};
  localparam logic [15:0] V_EX [NV] = '{16'h1212, 16'h0001, 16'h2222, 16'h04C0, 16'h4545};

  function automatic string vtag(input int v);
    case (v)
      0: return "R7";
      1: return "R6";
      2: return "R4/R5";
      3: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One request pulse; outputs sampled at the next falling edge
  task automatic pulse();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_grant(input string tag, input int g, input int r);
    pulse();
    chk({tag, " valid"}, int'(grant_valid), 1);
    chk({tag, " group"}, int'(grant_group), g);
    chk({tag, " ring"}, int'(grant_ring), r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", int'(grant_valid), 0);
    chk("R1 reset group", int'(grant_group), 0);
    chk("R1 reset ring", int'(grant_ring), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      do_reset();
      ne = V_NE[v];
      st = V_ST[v];
      wt = V_WT[v];
      for (int k = 0; k < 4; k++) begin
        logic [3:0] e;
        e = V_EX[v][15-4*k -: 4];
        expect_grant($sformatf("%s vec%0d grant%0d", vtag(v), v, k), int'(e[3:2]), int'(e[1:0]));
      end
    end

    // R2: no pending work gives no grant
    do_reset();
    ne = '0; st = '0; wt = {16{4'h1}};
    pulse();
    chk("R2 empty no valid", int'(grant_valid), 0);

    // R1 and R9: strict grant first, weighted rotation still starts at ring 0
    ne = 16'h000B; st = 16'h0008;
    expect_grant("R4 strict first", 0, 3);
    ne = 16'h0003;
    expect_grant("R9 weighted untouched", 0, 0);
    // R2: no request gives no valid, and the indices hold
    @(negedge clk);
    chk("R2 idle valid low", int'(grant_valid), 0);
    chk("R2 idle group hold", int'(grant_group), 0);
    chk("R2 idle ring hold", int'(grant_ring), 0);
    expect_grant("R6 next weighted", 0, 1);
    // R10: flat bit 14 is group 3 ring 2
    ne = 16'h4000;
    expect_grant("R10 flat index", 3, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule